// File: doc/BRIEF.md
# Boot Mode Sequencer and Block Loader

This block decides how the processor starts once reset is released. While reset is held it captures a 2-bit boot-mode input, a flag saying whether the reset was started by software, and a software bypass bit. In the first cycle after reset it picks one of three outcomes. It can jump straight into external memory. It can skip loading and jump into on-chip instruction memory, which is the bypass case and is taken only after a software reset. Otherwise it reads a load image from a byte stream.

A load image is a chain of blocks. Each block opens with a 10-byte header: a little-endian destination address, a little-endian byte count and a 16-bit flag word whose top bit marks the final block. The loader writes each payload byte to a byte-wide memory write port at consecutive addresses. A block whose count is zero writes nothing. After the final block the loader raises `done` and presents the start address. The byte source uses a valid/ready handshake. The loader applies back-pressure through `src_ready`, so it takes no byte it cannot use and loses none while it waits.

Top module: `boot_loader_top`

## Requirements
- R1: While `rst` is high, `done`, `wr_en`, `src_ready` and `src_sel` are 0. The mode, software-reset flag and bypass bit are taken from their values at the last clock edge of reset, and changes to those pins after reset has no effect.
- R2: After a software reset (`rst_from_sw`=1) with `cfg_bypass`=1, the block raises `done` with `start_pc` = 0xFFA0_0000 for any mode. It accepts no source byte and makes no memory write.
- R3: After a power-on reset (`rst_from_sw`=0), `cfg_bypass` is ignored and the outcome is set by `boot_mode` alone.
- R4: With `boot_mode` = 2'b00 and no bypass, the block raises `done` with `start_pc` = 0x2000_0000, accepts no byte and writes nothing.
- R5: With `boot_mode` set to 2'b01 (parallel flash), 2'b10 (SPI memory, loader as master) or 2'b11 (SPI host, loader as slave), `src_sel` equals that mode while loading and returns to 2'b00 once `done` is high.
- R6: A header is 10 bytes in stream order. Bytes 0–3 hold the destination address, least significant byte first. Bytes 4–7 hold the byte count, least significant byte first. Bytes 8–9 hold the flag word, least significant byte first. Flag bit 15 (bit 7 of byte 9) set marks the final block.
- R7: Payload byte i of a block is written once to destination address + i, in stream order, with one `wr_en` pulse per accepted byte.
- R8: A block with a count of zero writes nothing. The next byte is treated as a new header, or loading ends if that block is the final one.
- R9: Any number of blocks may be chained. After the final block's last byte (or its header, if its count is zero), `done` rises with `start_pc` = 0xFFA0_0000.
- R10: A byte is taken only in a cycle where `src_valid` and `src_ready` are both high. Cycles with `src_valid` low cause no loss, repetition or reordering of data.
- R11: Once high, `done` stays high and `start_pc` stays constant until the next reset, and `src_ready` is 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot pins are captured while high |
| boot_mode | input | 2 | Boot mode pins |
| rst_from_sw | input | 1 | 1 when the current reset was started by software |
| cfg_bypass | input | 1 | Software bypass request, used only after a software reset |
| src_valid | input | 1 | Byte source has a byte on `src_data` |
| src_ready | output | 1 | Loader accepts a byte this cycle |
| src_data | input | 8 | Source byte |
| wr_en | output | 1 | Memory write strobe, one byte |
| wr_addr | output | AW (32) | Memory write address |
| wr_data | output | 8 | Memory write byte |
| src_sel | output | 2 | Active load source while loading, 0 otherwise |
| done | output | 1 | Boot sequence finished |
| start_pc | output | AW (32) | Execution start address, valid with `done` |

## Verification
Two events can fall in the same cycle. The last payload byte of the final block produces its memory write on the same clock edge that raises `done` and loads `start_pc`. A byte arriving at a header boundary is also the point where a zero-count block must hand over to the next header or to completion. The bench builds images whose final block has data, images whose final block is empty, and images with an empty block in the middle, and it inserts random gaps in `src_valid`. Each run is judged by comparing the full list of observed writes with a list the bench builds while creating the image, comparing the number of bytes handed over with the image length, and checking the final `start_pc` and that `done` stays high afterwards.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    ST_DECIDE = 2'd0,
    ST_HDR    = 2'd1,
    ST_DATA   = 2'd2,
    ST_DONE   = 2'd3
  } boot_st_e;

  localparam logic [1:0] MODE_EXT_DIRECT = 2'b00;
  localparam int         FLAG_BYTES      = 2;

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_pins,
  input  logic       sw_pin,
  input  logic       byp_pin,
  output logic [1:0] mode_q,
  output logic       sw_q,
  output logic       byp_q
);

  // Pins are re-captured on every reset edge; the last one wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_pins;
      sw_q   <= sw_pin;
      byp_q  <= byp_pin;
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mode_q) && $stable(sw_q) && $stable(byp_q))); // R1

endmodule

// File: rtl/boot_hdr_parse.sv
module boot_hdr_parse #(
  parameter int AW      = 32,
  parameter int CW      = 32,
  parameter int HDR_LEN = AW/8 + CW/8 + boot_pkg::FLAG_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [7:0]    byte_in,
  output logic          hdr_done,
  output logic [AW-1:0] hdr_addr,
  output logic [CW-1:0] hdr_cnt,
  output logic          hdr_last
);

  localparam int AB = AW / 8;
  localparam int CB = CW / 8;
  localparam int IW = $clog2(HDR_LEN);

  logic [7:0]    hq [HDR_LEN];
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (take) begin
      idx <= (idx == IW'(HDR_LEN - 1)) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hq[idx] <= byte_in;
    end
  end

  assign hdr_done = take && (idx == IW'(HDR_LEN - 1));
  // The final header byte is the upper flag byte; its top bit ends the chain.
  assign hdr_last = byte_in[7];

  always_comb begin
    for (int i = 0; i < AB; i++) begin
      hdr_addr[8*i +: 8] = hq[i];
    end
    for (int i = 0; i < CB; i++) begin
      hdr_cnt[8*i +: 8] = hq[AB + i];
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, idx} < (IW+1)'(HDR_LEN))); // R6

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int            AW     = 32,
  parameter int            CW     = 32,
  parameter logic [AW-1:0] EXT_PC = 32'h2000_0000,
  parameter logic [AW-1:0] L1_PC  = 32'hFFA0_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_q,
  input  logic          sw_q,
  input  logic          byp_q,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_ready,
  output logic          hdr_take,
  input  logic          hdr_done,
  input  logic [AW-1:0] hdr_addr,
  input  logic [CW-1:0] hdr_cnt,
  input  logic          hdr_last,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [1:0]    src_sel,
  output logic          done,
  output logic [AW-1:0] start_pc
);

  boot_st_e      state;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] rem_q;
  logic          last_q;
  logic          take;

  assign src_ready = (state == ST_HDR) || (state == ST_DATA);
  assign take      = src_valid && src_ready;
  assign hdr_take  = take && (state == ST_HDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_DECIDE;
      done     <= 1'b0;
      start_pc <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      src_sel  <= 2'b00;
      dst_q    <= '0;
      rem_q    <= '0;
      last_q   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      unique case (state)
        ST_DECIDE: begin
          if (sw_q && byp_q) begin
            state    <= ST_DONE;
            done     <= 1'b1;
            start_pc <= L1_PC;
          end else if (mode_q == MODE_EXT_DIRECT) begin
            state    <= ST_DONE;
            done     <= 1'b1;
            start_pc <= EXT_PC;
          end else begin
            state   <= ST_HDR;
            src_sel <= mode_q;
          end
        end
        ST_HDR: begin
          if (hdr_done) begin
            if (hdr_cnt == '0) begin
              if (hdr_last) begin
                state    <= ST_DONE;
                done     <= 1'b1;
                start_pc <= L1_PC;
                src_sel  <= 2'b00;
              end
            end else begin
              state  <= ST_DATA;
              dst_q  <= hdr_addr;
              rem_q  <= hdr_cnt;
              last_q <= hdr_last;
            end
          end
        end
        ST_DATA: begin
          if (take) begin
            wr_en   <= 1'b1;
            wr_addr <= dst_q;
            wr_data <= src_data;
            dst_q   <= dst_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            if (rem_q == CW'(1)) begin
              if (last_q) begin
                state    <= ST_DONE;
                done     <= 1'b1;
                start_pc <= L1_PC;
                src_sel  <= 2'b00;
              end else begin
                state <= ST_HDR;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(src_valid && src_ready)); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(start_pc))); // R11

  AST_NO_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !src_ready); // R11

  AST_PC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (start_pc == EXT_PC || start_pc == L1_PC)); // R9

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (src_sel == 2'b00)); // R5

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> (src_sel == mode_q)); // R5

endmodule

// File: rtl/boot_loader_top.sv
module boot_loader_top #(
  parameter int            AW     = 32,
  parameter int            CW     = 32,
  parameter logic [AW-1:0] EXT_PC = 32'h2000_0000,
  parameter logic [AW-1:0] L1_PC  = 32'hFFA0_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    boot_mode,
  input  logic          rst_from_sw,
  input  logic          cfg_bypass,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [7:0]    src_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [1:0]    src_sel,
  output logic          done,
  output logic [AW-1:0] start_pc
);

  localparam int HDR_LEN = AW/8 + CW/8 + boot_pkg::FLAG_BYTES;

  logic [1:0]    mode_q;
  logic          sw_q;
  logic          byp_q;
  logic          hdr_take;
  logic          hdr_done;
  logic [AW-1:0] hdr_addr;
  logic [CW-1:0] hdr_cnt;
  logic          hdr_last;

  boot_mode_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .mode_pins (boot_mode),
    .sw_pin    (rst_from_sw),
    .byp_pin   (cfg_bypass),
    .mode_q    (mode_q),
    .sw_q      (sw_q),
    .byp_q     (byp_q)
  );

  boot_hdr_parse #(.AW(AW), .CW(CW), .HDR_LEN(HDR_LEN)) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .take     (hdr_take),
    .byte_in  (src_data),
    .hdr_done (hdr_done),
    .hdr_addr (hdr_addr),
    .hdr_cnt  (hdr_cnt),
    .hdr_last (hdr_last)
  );

  boot_ctrl #(.AW(AW), .CW(CW), .EXT_PC(EXT_PC), .L1_PC(L1_PC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .sw_q      (sw_q),
    .byp_q     (byp_q),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .hdr_take  (hdr_take),
    .hdr_done  (hdr_done),
    .hdr_addr  (hdr_addr),
    .hdr_cnt   (hdr_cnt),
    .hdr_last  (hdr_last),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .src_sel   (src_sel),
    .done      (done),
    .start_pc  (start_pc)
  );

endmodule

// File: tb/test_boot_loader_top.sv
module test_boot_loader_top;

  localparam logic [31:0] EXT_PC = 32'h2000_0000;
  localparam logic [31:0] L1_PC  = 32'hFFA0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  boot_mode = 2'b00;
  logic        rst_from_sw = 1'b0;
  logic        cfg_bypass = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [7:0]  src_data = 8'h00;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  src_sel;
  logic        done;
  logic [31:0] start_pc;

  always #10 clk = ~clk; // 50 MHz

  boot_loader_top i_boot_loader_top (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .rst_from_sw(rst_from_sw),
    .cfg_bypass(cfg_bypass), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_sel(src_sel), .done(done), .start_pc(start_pc)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  img   [0:1023];
  int          img_len;
  logic [31:0] exp_a [0:511];
  logic [7:0]  exp_d [0:511];
  int          exp_n;
  int          wr_seen;
  logic        mon_on = 1'b0;
  logic [1:0]  cur_mode;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Write and source-select monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (mon_on && wr_en) begin
      if (wr_seen < exp_n)
        check(wr_addr == exp_a[wr_seen] && wr_data == exp_d[wr_seen], "R7",
              "write addr/data", {wr_addr[23:0], wr_data},
              {exp_a[wr_seen][23:0], exp_d[wr_seen]});
      else
        check(1'b0, "R8", "unexpected write", wr_addr, 32'hFFFF_FFFF);
      wr_seen++;
    end
    if (mon_on && src_ready && src_sel != cur_mode)
      check(1'b0, "R5", "src_sel while loading", {30'd0, src_sel}, {30'd0, cur_mode});
  end

  task automatic clear_image();
    img_len = 0;
    exp_n   = 0;
  endtask

  task automatic add_block(input logic [31:0] addr, input int cnt, input bit last);
    logic [15:0] flags;
    flags = 16'($urandom) & 16'h7FFF;
    if (last) flags = flags | 16'h8000;
    for (int i = 0; i < 4; i++) begin img[img_len] = addr[8*i +: 8]; img_len++; end
    for (int i = 0; i < 4; i++) begin img[img_len] = 8'(cnt >> (8*i)); img_len++; end
    img[img_len] = flags[7:0];  img_len++;
    img[img_len] = flags[15:8]; img_len++;
    for (int i = 0; i < cnt; i++) begin
      img[img_len] = 8'($urandom);
      exp_a[exp_n] = addr + 32'(i);
      exp_d[exp_n] = img[img_len];
      exp_n++;
      img_len++;
    end
  endtask

  function automatic logic [31:0] exp_pc(input logic [1:0] m, input bit sw, input bit byp);
    if (sw && byp) return L1_PC;
    if (m == 2'b00) return EXT_PC;
    return L1_PC;
  endfunction

  task automatic run_case(input logic [1:0] m, input bit sw, input bit byp,
                          input bit loads, input string tag);
    int k;
    int guard;
    logic [31:0] pc_hold;
    rst = 1'b1;
    src_valid = 1'b0;
    boot_mode = m; rst_from_sw = sw; cfg_bypass = byp;
    cur_mode = m;
    wr_seen = 0;
    repeat (3) @(negedge clk);
    check(!done && !wr_en && !src_ready && src_sel == 2'b00, "R1", "outputs in reset",
          {28'd0, done, wr_en, src_ready, |src_sel}, 32'd0);
    mon_on = 1'b1;
    rst = 1'b0;
    // Pins move after reset; the latched values must govern.
    boot_mode = ~m; cfg_bypass = ~byp; rst_from_sw = ~sw;
    k = 0; guard = 0;
    while (k < img_len && !done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (done) break;
      if ($urandom % 4 == 0) begin
        src_valid = 1'b0;
        src_data  = 8'($urandom);
      end else begin
        src_valid = 1'b1;
        src_data  = img[k];
        if (src_ready) k++;
      end
    end
    @(negedge clk);
    src_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    check(done, "R9", {tag, " done raised"}, {31'd0, done}, 32'd1);
    check(start_pc == exp_pc(m, sw, byp), sw && byp ? "R2" : (m == 2'b00 ? "R4" : "R9"),
          {tag, " start_pc"}, start_pc, exp_pc(m, sw, byp));
    check(k == (loads ? img_len : 0), "R10", {tag, " bytes taken"}, 32'(k),
          32'(loads ? img_len : 0));
    pc_hold = start_pc;
    // Offer more bytes after completion; none may be taken.
    src_valid = 1'b1; src_data = 8'hA5;
    repeat (5) @(negedge clk);
    src_valid = 1'b0;
    check(done && start_pc == pc_hold && !src_ready && src_sel == 2'b00, "R11",
          {tag, " hold after done"}, start_pc, pc_hold);
    check(wr_seen == (loads ? exp_n : 0), "R7", {tag, " write count"}, 32'(wr_seen),
          32'(loads ? exp_n : 0));
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));

    // R4 and R3: power-on reset, mode 00, bypass requested but ignored.
    clear_image(); add_block(32'h0000_0100, 4, 1'b1);
    run_case(2'b00, 1'b0, 1'b1, 1'b0, "R3_R4 ext");

    // R2: software reset with bypass, loading mode selected.
    clear_image(); add_block(32'h0000_0200, 4, 1'b1);
    run_case(2'b01, 1'b1, 1'b1, 1'b0, "R2 bypass");

    // R4: software reset without bypass, mode 00.
    clear_image(); add_block(32'h0000_0300, 4, 1'b1);
    run_case(2'b00, 1'b1, 1'b0, 1'b0, "R4 sw ext");

    // R6 R7: single block, SPI memory source, address bytes all distinct.
    clear_image(); add_block(32'h1234_5678, 9, 1'b1);
    run_case(2'b10, 1'b1, 1'b0, 1'b1, "R6 single");

    // R8 R9: empty block in the middle of a chain.
    clear_image();
    add_block(32'hFFA0_0000, 5, 1'b0);
    add_block(32'h0BAD_0000, 0, 1'b0);
    add_block(32'hFF80_0010, 7, 1'b1);
    run_case(2'b01, 1'b0, 1'b0, 1'b1, "R8 mid empty");

    // R8: final block empty, host source.
    clear_image();
    add_block(32'h0000_4000, 3, 1'b0);
    add_block(32'h0000_0000, 0, 1'b1);
    run_case(2'b11, 1'b0, 1'b0, 1'b1, "R8 last empty");

    // R9 R10: random chains with random gaps.
    for (int n = 0; n < 6; n++) begin
      int nb;
      logic [1:0] m;
      clear_image();
      nb = 1 + int'($urandom % 4);
      m  = 2'(1 + $urandom % 3);
      for (int b = 0; b < nb; b++)
        add_block($urandom, int'($urandom % 21), b == nb - 1);
      run_case(m, 1'($urandom), 1'b0, 1'b1, "R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule